// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple synchronous host port and an asynchronous 64K x 16 dynamic RAM. The DRAM has a multiplexed 8-bit address bus, one row strobe and two column strobes, one per data byte. The host issues one access at a time, either a read or a write, with a 16-bit word address and a 2-bit byte enable. The controller splits the address into an 8-bit row and an 8-bit column. It drives the row strobe, the two column strobes, write enable and output enable, and it returns read data with a one-cycle valid pulse.

The controller keeps the last activated row open. A later request to the same row toggles only the column strobes. A request to another row first raises the row strobe for the precharge time and then activates the new row. A free-running timer asks for a refresh at a fixed interval. The refresh waits until any access already accepted has finished. It then closes the open page and runs a column-before-row cycle, which drops both column strobes before the row strobe, so no row counter is needed on this side. Every pulse width and gap is a cycle-count parameter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, for INIT_CYC cycles, every strobe output is high (inactive), the data drive enable is low, host_ready is low and host_rvalid is low.
- R2: A row is activated with host_addr[15:8] on dram_addr when dram_ras_n falls. The column host_addr[7:0] is on dram_addr, and held steady, for as long as a column strobe is low.
- R3: host_be bit 0 selects data bits 7:0 through dram_casl_n, and bit 1 selects bits 15:8 through dram_cash_n. A value of 2'b11 or 2'b00 is a full-word access that lowers both strobes together.
- R4: A write with one byte enabled lowers only that byte's column strobe. The other byte of the stored word is left unchanged.
- R5: On a read, dram_oe_n is low while the column strobes are low. Data is captured RD_LAT cycles after the column strobe falls. host_rvalid is a one-cycle pulse, and a byte that is not enabled reads as zero.
- R6: A page hit (same row as the open row) causes no row activation. host_rvalid is high in cycle RD_LAT+1 after the accepting clock edge.
- R7: A request to a closed row gives host_rvalid in cycle T_RCD+RD_LAT+1. A request that misses an open row gives it in cycle T_RP+T_RCD+RD_LAT+1. Before each fall, dram_ras_n has been high for at least T_RP cycles.
- R8: One refresh is performed every REF_INT cycles. In a refresh cycle, both column strobes are low before dram_ras_n falls, and dram_we_n and dram_oe_n stay high.
- R9: dram_dq_oe is high only while dram_we_n is low, and it is never high while dram_oe_n is low.
- R10: A refresh closes an open page, so the first access after it needs a row activation even if it names the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address, row in [15:8], column in [7:0] |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Request accepted on this edge when high together with host_req |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe |
| dram_casl_n | output | 1 | Low-byte column strobe |
| dram_cash_n | output | 1 | High-byte column strobe |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The vector walk applies full-word writes, low-only and high-only writes, a write with zero enables and single-byte reads to one word. Stale bytes, swapped strobes or missing masking therefore each give a different read-back value. A second row in the walk shows whether the row and column halves of the address are swapped. Timed reads to a closed row, to the open row and to another row separate the three access paths by latency and by activation count. Idle intervals, and accesses placed around a refresh, show the refresh rate and that a refresh closes the page.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_PRE, S_ACT, S_COL, S_CPRE, S_RCAS, S_RRAS
  } fpm_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // page hit: a row is open and the request names it
  function automatic logic row_match(input logic open, input logic [7:0] open_row,
                                     input logic [15:0] addr);
    return open && (addr[15:8] == open_row);
  endfunction

  // zero enables mean a full word
  function automatic logic [1:0] norm_be(input logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction

  function automatic logic [15:0] be_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int unsigned REF_INT = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pend
);
  localparam int unsigned CW = $clog2(REF_INT + 1);

  logic [CW-1:0] tmr;
  logic          tick;

  assign tick = run && (tmr == CW'(REF_INT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      pend <= 1'b0;
    end else begin
      if (run) tmr <= tick ? '0 : tmr + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_rd_capture.sv
module fpm_rd_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [1:0]  be,
  input  logic [15:0] dq_in,
  output logic [15:0] rdata,
  output logic        rvalid
);
  import fpm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap_en;
      if (cap_en) rdata <= dq_in & be_mask(be);
    end
  end
endmodule

// File: rtl/fpm_sequencer.sv
module fpm_sequencer #(
  parameter int unsigned INIT_CYC = 50000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RCD    = 2,
  parameter int unsigned T_CAS    = 2,
  parameter int unsigned RD_LAT   = 2,
  parameter int unsigned T_CP     = 1,
  parameter int unsigned T_CSR    = 1,
  parameter int unsigned T_RAS    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [15:0] host_addr,
  input  logic [1:0]  host_be,
  input  logic [15:0] host_wdata,
  output logic        host_ready,
  input  logic        ref_pend,
  output logic        ref_ack,
  output logic        init_done,
  output logic        cap_en,
  output logic [1:0]  op_be,
  output logic        ras_n,
  output logic        casl_n,
  output logic        cash_n,
  output logic        we_n,
  output logic        oe_n,
  output logic [7:0]  dram_addr,
  output logic [15:0] dq_out,
  output logic        dq_oe
);
  import fpm_pkg::*;

  localparam int unsigned CAS_LEN = max2(T_CAS, RD_LAT);
  localparam int unsigned MAXV    = max2(max2(INIT_CYC, max2(T_RP, T_RCD)),
                                         max2(max2(CAS_LEN, T_CP), max2(T_CSR, T_RAS)));
  localparam int unsigned CW      = $clog2(MAXV + 1);

  fpm_state_t    state, state_nx;
  logic [CW-1:0] cnt, lim;
  logic          cnt_last, accept, hit;
  logic          op_pend, op_we, row_open;
  logic [15:0]   op_addr, op_wdata;
  logic [7:0]    open_row;

  always_comb begin
    unique case (state)
      S_INIT:  lim = CW'(INIT_CYC);
      S_PRE:   lim = CW'(T_RP);
      S_ACT:   lim = CW'(T_RCD);
      S_COL:   lim = CW'(CAS_LEN);
      S_CPRE:  lim = CW'(T_CP);
      S_RCAS:  lim = CW'(T_CSR);
      S_RRAS:  lim = CW'(T_RAS);
      default: lim = CW'(1);
    endcase
  end

  assign cnt_last   = (cnt == lim - 1'b1);
  assign host_ready = (state == S_IDLE) && !ref_pend;
  assign accept     = host_ready && host_req;
  assign hit        = row_match(row_open, open_row, host_addr);
  assign ref_ack    = (state == S_RRAS) && cnt_last;
  assign init_done  = (state != S_INIT);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_INIT: if (cnt_last) state_nx = S_IDLE;
      S_IDLE: begin
        if (ref_pend)    state_nx = row_open ? S_PRE : S_RCAS;
        else if (accept) state_nx = hit ? S_COL : (row_open ? S_PRE : S_ACT);
      end
      S_PRE:  if (cnt_last) state_nx = op_pend ? S_ACT : (ref_pend ? S_RCAS : S_IDLE);
      S_ACT:  if (cnt_last) state_nx = S_COL;
      S_COL:  if (cnt_last) state_nx = S_CPRE;
      S_CPRE: if (cnt_last) state_nx = S_IDLE;
      S_RCAS: if (cnt_last) state_nx = S_RRAS;
      S_RRAS: if (cnt_last) state_nx = S_PRE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_INIT;
      cnt      <= '0;
      op_pend  <= 1'b0;
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_be    <= 2'b11;
      op_wdata <= '0;
      row_open <= 1'b0;
      open_row <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != state) cnt <= '0;
      else if (!cnt_last)    cnt <= cnt + 1'b1;
      if (accept) begin
        op_pend  <= 1'b1;
        op_we    <= host_we;
        op_addr  <= host_addr;
        op_be    <= norm_be(host_be);
        op_wdata <= host_wdata;
      end else if (state == S_CPRE && cnt_last) begin
        op_pend <= 1'b0;
      end
      if (state == S_ACT) begin
        row_open <= 1'b1;
        open_row <= op_addr[15:8];
      end else if (state == S_PRE || state == S_RCAS) begin
        row_open <= 1'b0;
      end
    end
  end

  // strobes decoded from registered state only
  always_comb begin
    ras_n     = !((state inside {S_ACT, S_COL, S_CPRE, S_RRAS}) ||
                  (state == S_IDLE && row_open));
    casl_n    = !((state == S_COL && op_be[0]) || state == S_RCAS || state == S_RRAS);
    cash_n    = !((state == S_COL && op_be[1]) || state == S_RCAS || state == S_RRAS);
    we_n      = !(state == S_COL && op_we);
    dq_oe     = (state == S_COL) && op_we;
    oe_n      = !(state == S_COL && !op_we);
    dram_addr = (state == S_ACT) ? op_addr[15:8] :
                (state == S_COL) ? op_addr[7:0]  : 8'h00;
    dq_out    = op_wdata;
    cap_en    = (state == S_COL) && !op_we && (cnt == CW'(RD_LAT - 1));
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int unsigned INIT_CYC = 50000,
  parameter int unsigned REF_INT  = 3900,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RCD    = 2,
  parameter int unsigned T_CAS    = 2,
  parameter int unsigned RD_LAT   = 2,
  parameter int unsigned T_CP     = 1,
  parameter int unsigned T_CSR    = 1,
  parameter int unsigned T_RAS    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [15:0] host_addr,
  input  logic [1:0]  host_be,
  input  logic [15:0] host_wdata,
  output logic        host_ready,
  output logic        host_rvalid,
  output logic [15:0] host_rdata,
  output logic        dram_ras_n,
  output logic        dram_casl_n,
  output logic        dram_cash_n,
  output logic        dram_we_n,
  output logic        dram_oe_n,
  output logic [7:0]  dram_addr,
  output logic [15:0] dram_dq_out,
  output logic        dram_dq_oe,
  input  logic [15:0] dram_dq_in
);
  logic       ref_pend, ref_ack, init_done, cap_en;
  logic [1:0] op_be;

  fpm_refresh_timer #(.REF_INT(REF_INT)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(init_done), .ack(ref_ack), .pend(ref_pend)
  );

  fpm_sequencer #(
    .INIT_CYC(INIT_CYC), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .RD_LAT(RD_LAT), .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS(T_RAS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .host_ready(host_ready),
    .ref_pend(ref_pend), .ref_ack(ref_ack), .init_done(init_done),
    .cap_en(cap_en), .op_be(op_be),
    .ras_n(dram_ras_n), .casl_n(dram_casl_n), .cash_n(dram_cash_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dq_out(dram_dq_out), .dq_oe(dram_dq_oe)
  );

  fpm_rd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .be(op_be),
    .dq_in(dram_dq_in), .rdata(host_rdata), .rvalid(host_rvalid)
  );
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int unsigned T_RP = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       casl_n,
  input logic       cash_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       dq_oe,
  input logic [7:0] addr,
  input logic       rvalid,
  input logic       cap_en,
  input logic       ref_ack
);
  logic [15:0] hi_cnt;
  logic        cas_any;
  assign cas_any = !casl_n || !cash_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!ras_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  p_rp_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(T_RP)));

  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_any) |-> (!casl_n && !cash_n && we_n && oe_n));

  p_ref_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> (!ras_n && !casl_n && !cash_n));

  p_wr_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && !ras_n && cas_any));

  p_no_contend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_any && !ras_n && $past(cas_any && !ras_n)) |-> $stable(addr));

  p_rv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  p_cap_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (!oe_n && cas_any));
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(.T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .casl_n(dram_casl_n),
  .cash_n(dram_cash_n), .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .addr(dram_addr), .rvalid(host_rvalid), .cap_en(cap_en), .ref_ack(ref_ack)
);

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb_top;
  localparam int INIT_CYC = 20;
  localparam int REF_INT  = 400;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, RD_LAT = 2, T_CP = 1, T_CSR = 1, T_RAS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [1:0]  host_be = 2'b11;
  logic host_ready, host_rvalid;
  logic [15:0] host_rdata;
  logic ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
  logic [7:0]  dram_addr;
  logic [15:0] dq_out, dq_in;

  always #2 clk = ~clk;

  fpm_dram_ctrl #(
    .INIT_CYC(INIT_CYC), .REF_INT(REF_INT), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .RD_LAT(RD_LAT), .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS(T_RAS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .dram_ras_n(ras_n), .dram_casl_n(casl_n), .dram_cash_n(cash_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  // small DRAM model: 16 rows x 16 columns, sampled at the falling clock edge
  logic [15:0] mem [256];
  logic [7:0]  m_row = '0, last_row = '0, last_col = '0;
  logic        prev_ras = 1'b1;
  int          ref_cnt = 0, act_cnt = 0;

  assign dq_in = (!oe_n && !ras_n) ? mem[{m_row[3:0], dram_addr[3:0]}] : 16'h0000;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (prev_ras && !ras_n) begin
      if (!casl_n && !cash_n) ref_cnt++;
      else begin m_row = dram_addr; last_row = dram_addr; act_cnt++; end
    end
    if (!ras_n && (!casl_n || !cash_n) && (!we_n || !oe_n)) last_col = dram_addr;
    if (!ras_n && !we_n && dq_oe) begin
      if (!casl_n) mem[{m_row[3:0], dram_addr[3:0]}][7:0]  = dq_out[7:0];
      if (!cash_n) mem[{m_row[3:0], dram_addr[3:0]}][15:8] = dq_out[15:8];
    end
    prev_ras = ras_n;
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one host access; lat = falling edge index (1 = first after accept) where rvalid seen
  task automatic host_op(input logic we, input logic [15:0] a, input logic [1:0] be,
                         input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_req = 1'b0;
    lat = 1;
    rd  = '0;
    if (!we) begin
      while (!host_rvalid) begin @(negedge clk); lat++; end
      rd = host_rdata;
    end
    while (!host_ready) @(negedge clk);
  endtask

  task automatic wait_refresh();
    int c0 = ref_cnt;
    while (ref_cnt == c0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // {we, addr, be, wdata, expected}
  localparam logic [50:0] VEC [10] = '{
    {1'b1, 16'h0102, 2'b11, 16'hA1B2, 16'h0000},
    {1'b0, 16'h0102, 2'b11, 16'h0000, 16'hA1B2},
    {1'b1, 16'h0102, 2'b01, 16'h77CC, 16'h0000},
    {1'b0, 16'h0102, 2'b11, 16'h0000, 16'hA1CC},
    {1'b1, 16'h0102, 2'b10, 16'h55EE, 16'h0000},
    {1'b0, 16'h0102, 2'b10, 16'h0000, 16'h5500},
    {1'b0, 16'h0102, 2'b01, 16'h0000, 16'h00CC},
    {1'b1, 16'h0A0F, 2'b00, 16'h1234, 16'h0000},
    {1'b0, 16'h0A0F, 2'b11, 16'h0000, 16'h1234},
    {1'b0, 16'h0102, 2'b11, 16'h0000, 16'h55CC}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    int lat, a0, r0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 strobes in reset", {ras_n, casl_n, cash_n, we_n, oe_n, dq_oe},
          6'b111110);
    check("R1 ready in reset", {host_ready, host_rvalid}, 2'b00);
    rst_n = 1'b1;
    repeat (INIT_CYC - 4) @(negedge clk);
    check("R1 ready low during init", {host_ready, ras_n, casl_n, cash_n}, 4'b0111);
    repeat (8) @(negedge clk);
    check("R1 ready after init", host_ready, 1'b1);

    // vector walk: R2 R3 R4 R5
    foreach (VEC[i]) begin
      host_op(VEC[i][50], VEC[i][49:34], VEC[i][33:32], VEC[i][31:16], rd, lat);
      check("R2 row latched", last_row, VEC[i][49:42]);
      check("R2 column latched", last_col, VEC[i][41:34]);
      if (!VEC[i][50]) check("R3 R4 R5 read data", rd, VEC[i][15:0]);
    end

    // latency paths after a fresh refresh: R6 R7
    wait_refresh();
    a0 = act_cnt;
    host_op(1'b0, 16'h0305, 2'b11, 16'h0, rd, lat);
    check("R7 closed-row latency", lat, T_RCD + RD_LAT + 1);
    check("R7 one activation", act_cnt - a0, 1);
    a0 = act_cnt;
    host_op(1'b0, 16'h0306, 2'b11, 16'h0, rd, lat);
    check("R6 page-hit latency", lat, RD_LAT + 1);
    check("R6 no activation on hit", act_cnt - a0, 0);
    host_op(1'b0, 16'h0705, 2'b11, 16'h0, rd, lat);
    check("R7 open-miss latency", lat, T_RP + T_RCD + RD_LAT + 1);
    check("R7 miss activates", act_cnt - a0, 1);

    // R8: refresh rate over idle time
    r0 = ref_cnt;
    repeat (4 * REF_INT) @(negedge clk);
    check("R8 refresh count in 4 intervals",
          ((ref_cnt - r0) >= 3 && (ref_cnt - r0) <= 5), 1'b1);

    // R10: refresh closes the page
    wait_refresh();
    host_op(1'b0, 16'h0305, 2'b11, 16'h0, rd, lat);
    wait_refresh();
    a0 = act_cnt;
    host_op(1'b0, 16'h0306, 2'b11, 16'h0, rd, lat);
    check("R10 same row after refresh is miss", lat, T_RCD + RD_LAT + 1);
    check("R10 reactivation", act_cnt - a0, 1);

    // R9: bus released while idle
    check("R9 drive off when idle", {dq_oe, we_n}, 2'b01);
    finish_run();
  end
endmodule